// File: doc/BRIEF.md
# Bus Controller Frame and Gap Timer

This block times the message schedule of a bus controller that sends its traffic in repeating frames. The host programs a frame period in units of 100 µs and an intermessage gap in units of 1 µs. A start pulse opens a frame. From then on a frame countdown shows how much of the frame is left. When the countdown runs out, the block either stops or, with auto-repeat on, opens the next frame at once. A separate message countdown is loaded from the gap value each time the controller reports a finished message. A level output tells the sequencer when the next message may go out.

Both time bases are derived from the system clock. A parameter sets the number of clocks per microsecond. Each countdown has its own prescaler, and that prescaler is realigned when its countdown is loaded, so frame and gap lengths are exact multiples of the clock period. The host sees four 16-bit words through a small register port: the two settings, which it can read and write, and the two remaining times, which it can only read.

Top module: `bc_frame_timer`

## Requirements
- R1: With C clocks per microsecond, the frame countdown steps down once every 100·C clocks, counted from the clock edge that loaded it. The message countdown steps down once every C clocks, counted from its own load edge.
- R2: Register address 0 holds the frame time and address 1 holds the intermessage gap. Both can be written with host_wr and read back on host_rdata. Both reset to 0.
- R3: When start is sampled high (and stop is low), frame_start pulses for one cycle after that edge and frame_active goes high. At the same edge the frame remaining value is loaded from the frame time.
- R4: Address 2 reads the frame remaining value, which counts down in 100 µs units while a frame is active.
- R5: A frame loaded with a frame time F ≥ 1 expires after F of its 100 µs steps. frame_end pulses for one cycle at that point.
- R6: If auto_repeat is high at expiry, the frame remaining value is reloaded from the frame time. frame_start pulses in the same cycle as frame_end, and the frames continue back to back with no lost time.
- R7: If auto_repeat is low at expiry, frame_active falls and the frame remaining value holds at 0. No further pulses follow until the next start.
- R8: msg_done loads the message countdown from the gap value. next_msg_ok is low while that countdown is non-zero, and it rises G·C clocks after the load edge for a gap G.
- R9: Address 3 reads the message remaining value. It holds at 0 once it gets there and never wraps.
- R10: stop halts both countdowns at their present values. frame_active goes low, no further frame pulses come, and next_msg_ok stays as it is until the next load. stop wins over start or msg_done in the same cycle.
- R11: Host writes to addresses 2 and 3 have no effect on either remaining value.
- R12: A msg_done that arrives while a gap is still counting restarts the gap from the full gap value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 2 | Host register address (0 frame time, 1 gap, 2 frame left, 3 gap left) |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for host_addr |
| start | input | 1 | Open a frame |
| stop | input | 1 | Halt both timers and end frame sequencing |
| auto_repeat | input | 1 | Restart the frame on expiry |
| msg_done | input | 1 | A message finished; start the intermessage gap |
| frame_start | output | 1 | One-cycle pulse at each frame opening |
| frame_end | output | 1 | One-cycle pulse at each frame expiry |
| frame_active | output | 1 | A frame is being timed |
| next_msg_ok | output | 1 | Gap countdown is at zero |

## Verification
The bench aims at the exact cycles where the timers change. A prescaler that is not realigned on load, or that is off by one, would move frame_end or the rise of next_msg_ok by one or more microseconds. In auto-repeat, a design that lost a step at the reload would drift the second frame, and one that issued frame_start a cycle late would break the pairing of frame_start with frame_end. The bench also checks the last count before zero and the hold at zero, because a countdown that wraps would show a large value there. It checks that stop freezes the values instead of clearing them and that stop beats start, and it checks that a gap retriggered mid-count restarts from the full value instead of keeping its remainder.

// File: rtl/bcft_pkg.sv
// Shared definitions for the frame and gap timer.
// Assumes a two-bit host register address.
package bcft_pkg;
    typedef enum logic [1:0] {
        REG_FRAME_TIME = 2'd0,
        REG_GAP_TIME   = 2'd1,
        REG_FRAME_LEFT = 2'd2,
        REG_GAP_LEFT   = 2'd3
    } bcft_reg_e;
endpackage

// File: rtl/bcft_tick_div.sv
// Divide-by-DIV enable generator. tick is high in the cycle in which the
// DIV-th qualifying enable arrives since the last clear. clr realigns the
// phase so that the first tick comes DIV enables after the clearing edge.
// Assumes DIV >= 1.
module bcft_tick_div #(
    parameter int unsigned DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic tick
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    // phase counter: cleared on realign, wraps at DIV-1
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign tick = en && (cnt == LAST);

    // R1: a divider above one never ticks on two cycles in a row
    p_tick_spaced_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (DIV > 1 && tick && !clr) |=> !tick);
endmodule

// File: rtl/bcft_frame_ctr.sv
// Frame countdown and repeat sequencer. Loads on start, steps on each
// frame-resolution tick, and on expiry either reloads (auto_repeat) or
// stops. stop freezes the count and ends sequencing; it wins over start.
// Assumes slot_tick is aligned to the load edge by the caller.
module bcft_frame_ctr #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         stop,
    input  logic         auto_repeat,
    input  logic         slot_tick,
    input  logic [W-1:0] frame_time,
    output logic [W-1:0] remain,
    output logic         frame_start,
    output logic         frame_end,
    output logic         active
);
    // frame state: load, count down, expire, repeat or halt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain      <= '0;
            frame_start <= 1'b0;
            frame_end   <= 1'b0;
            active      <= 1'b0;
        end else begin
            frame_start <= 1'b0;
            frame_end   <= 1'b0;
            if (stop) begin
                active <= 1'b0;
            end else if (start) begin
                active      <= 1'b1;
                remain      <= frame_time;
                frame_start <= 1'b1;
            end else if (active && slot_tick) begin
                if (remain <= W'(1)) begin
                    frame_end <= 1'b1;
                    if (auto_repeat) begin
                        remain      <= frame_time;
                        frame_start <= 1'b1;
                    end else begin
                        remain <= '0;
                        active <= 1'b0;
                    end
                end else begin
                    remain <= remain - 1'b1;
                end
            end
        end
    end

    // R3: an opening frame carries the frame time present at the load edge
    p_start_loads_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(start) && !$past(stop)) |-> (remain == $past(frame_time)));

    // R10: stop is never followed by a frame pulse
    p_stop_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!frame_start && !frame_end && !active));

    // R5: expiry only comes from the last step of the count
    p_end_at_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> ($past(remain) <= W'(1)));

    // R7: an idle frame count does not move without a start
    p_idle_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !start) |=> $stable(remain));
endmodule

// File: rtl/bcft_gap_ctr.sv
// Intermessage gap countdown. msg_load reloads it from the gap value,
// each microsecond tick steps it toward zero, and it holds at zero.
// stop freezes it until the next load; stop wins over a load.
module bcft_gap_ctr #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         msg_load,
    input  logic         stop,
    input  logic         us_tick,
    input  logic [W-1:0] gap_time,
    output logic [W-1:0] remain,
    output logic         next_ok
);
    logic running;

    // gap state: reload, step down, freeze on stop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain  <= '0;
            running <= 1'b0;
        end else if (stop) begin
            running <= 1'b0;
        end else if (msg_load) begin
            remain  <= gap_time;
            running <= 1'b1;
        end else if (running && us_tick && remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign next_ok = (remain == '0);

    // R9: once at zero the gap stays at zero until reloaded
    p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (remain == '0 && !msg_load) |=> (remain == '0));

    // R8: a non-zero gap load withdraws permission on the next cycle
    p_load_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_load && !stop && gap_time != '0) |=> !next_ok);
endmodule

// File: rtl/bc_frame_timer.sv
// Top of the frame and gap timer: host register port, the two prescaler
// chains (microsecond and frame resolution for frames, microsecond for
// gaps) and the two countdowns. Each prescaler is realigned when its
// countdown loads. Assumes CLK_PER_US clocks make one microsecond.
module bc_frame_timer
    import bcft_pkg::*;
#(
    parameter int unsigned CLK_PER_US   = 50,
    parameter int unsigned US_PER_FRAME = 100,
    parameter int unsigned WORD_W       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [1:0]        host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    input  logic              start,
    input  logic              stop,
    input  logic              auto_repeat,
    input  logic              msg_done,
    output logic              frame_start,
    output logic              frame_end,
    output logic              frame_active,
    output logic              next_msg_ok
);
    logic [WORD_W-1:0] frame_time_q;
    logic [WORD_W-1:0] gap_time_q;
    logic [WORD_W-1:0] frame_left;
    logic [WORD_W-1:0] gap_left;
    logic              frame_us_tick;
    logic              frame_slot_tick;
    logic              gap_us_tick;
    logic              frame_realign;
    logic              gap_realign;

    assign frame_realign = start && !stop;
    assign gap_realign   = msg_done && !stop;

    // host-writable settings; the remaining-time words have no storage here
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_time_q <= '0;
            gap_time_q   <= '0;
        end else if (host_wr) begin
            case (bcft_reg_e'(host_addr))
                REG_FRAME_TIME: frame_time_q <= host_wdata;
                REG_GAP_TIME:   gap_time_q   <= host_wdata;
                default: ;
            endcase
        end
    end

    // host read multiplexer
    always_comb begin
        case (bcft_reg_e'(host_addr))
            REG_FRAME_TIME: host_rdata = frame_time_q;
            REG_GAP_TIME:   host_rdata = gap_time_q;
            REG_FRAME_LEFT: host_rdata = frame_left;
            default:        host_rdata = gap_left;
        endcase
    end

    bcft_tick_div #(.DIV(CLK_PER_US)) u_frame_us (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (frame_realign),
        .en   (1'b1),
        .tick (frame_us_tick)
    );

    bcft_tick_div #(.DIV(US_PER_FRAME)) u_frame_slot (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (frame_realign),
        .en   (frame_us_tick),
        .tick (frame_slot_tick)
    );

    bcft_tick_div #(.DIV(CLK_PER_US)) u_gap_us (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (gap_realign),
        .en   (1'b1),
        .tick (gap_us_tick)
    );

    bcft_frame_ctr #(.W(WORD_W)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .stop       (stop),
        .auto_repeat(auto_repeat),
        .slot_tick  (frame_slot_tick),
        .frame_time (frame_time_q),
        .remain     (frame_left),
        .frame_start(frame_start),
        .frame_end  (frame_end),
        .active     (frame_active)
    );

    bcft_gap_ctr #(.W(WORD_W)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .msg_load(msg_done),
        .stop    (stop),
        .us_tick (gap_us_tick),
        .gap_time(gap_time_q),
        .remain  (gap_left),
        .next_ok (next_msg_ok)
    );

    // R6: with auto-repeat held, an expiry is paired with a reopening
    p_repeat_pairs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(frame_end) && $past(auto_repeat)) |-> frame_start);

    // R11: host writes to read-only words leave the settings untouched
    p_ro_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr[1]) |=> ($stable(frame_time_q) && $stable(gap_time_q)));
endmodule

// File: tb/bc_frame_timer_test.sv
module bc_frame_timer_test;
    localparam int CPU  = 2;
    localparam int SLOT = CPU * 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        start = 1'b0, stop = 1'b0, auto_repeat = 1'b0, msg_done = 1'b0;
    logic        frame_start, frame_end, frame_active, next_msg_ok;

    always #10 clk = ~clk;

    bc_frame_timer #(.CLK_PER_US(CPU), .US_PER_FRAME(100), .WORD_W(16)) uut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .start(start),
        .stop(stop), .auto_repeat(auto_repeat), .msg_done(msg_done),
        .frame_start(frame_start), .frame_end(frame_end),
        .frame_active(frame_active), .next_msg_ok(next_msg_ok)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    // scoreboard: expected event cycle, event bits {ok_rise, end, start}, tag
    int    exp_cyc[$];
    int    exp_ev[$];
    string exp_req[$];
    bit    mon_on = 0;
    logic  prev_ok = 1'b1;
    logic [2:0] seen;

    task automatic check(input string req, input int act, input int exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic expect_ev(input int c, input int ev, input string req);
        exp_cyc.push_back(c);
        exp_ev.push_back(ev);
        exp_req.push_back(req);
    endtask

    // monitor: pops and compares each observed event against the queue
    always @(negedge clk) begin
        if (mon_on) begin
            seen = {next_msg_ok && !prev_ok, frame_end, frame_start};
            if (seen != 3'b000) begin
                if (exp_cyc.size() == 0) begin
                    n_chk++;
                    n_err++;
                    $display("FAIL R10 unexpected event: actual=%0d expected=0 at cycle %0d", seen, cyc);
                end else begin
                    check(exp_req[0], cyc, exp_cyc[0], "event cycle");
                    check(exp_req[0], int'(seen), exp_ev[0], "event kind");
                    void'(exp_cyc.pop_front());
                    void'(exp_ev.pop_front());
                    void'(exp_req.pop_front());
                end
            end
        end
        prev_ok = next_msg_ok;
    end

    task automatic wait_to(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, input int exp, input string req, input string what);
        host_addr = a;
        #1;
        check(req, int'(host_rdata), exp, what);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    // drivers: called at a falling edge; return the rising edge that samples
    task automatic do_start(output int p);
        start = 1'b1; p = cyc + 1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic do_msg(output int k);
        msg_done = 1'b1; k = cyc + 1;
        @(negedge clk);
        msg_done = 1'b0;
    endtask

    task automatic do_stop(output int s);
        stop = 1'b1; s = cyc + 1;
        @(negedge clk);
        stop = 1'b0;
    endtask

    // watchdog
    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int p, k, k2, s;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        prev_ok = next_msg_ok;
        mon_on = 1;

        // reset state (R2)
        rd(2'd0, 0, "R2", "frame time reset");
        rd(2'd1, 0, "R2", "gap reset");
        check("R9", int'(next_msg_ok), 1, "next_msg_ok after reset");
        check("R7", int'(frame_active), 0, "frame_active after reset");

        // settings round trip (R2) and read-only words (R11)
        wr(2'd0, 16'd3);
        wr(2'd1, 16'd5);
        wr(2'd2, 16'h1234);
        wr(2'd3, 16'h00ff);
        rd(2'd0, 3, "R2", "frame time readback");
        rd(2'd1, 5, "R2", "gap readback");
        rd(2'd2, 0, "R11", "frame left after write");
        rd(2'd3, 0, "R11", "gap left after write");

        // single frame, no repeat (R3 R4 R5 R7 R1)
        auto_repeat = 1'b0;
        do_start(p);
        expect_ev(p, 1, "R3");
        expect_ev(p + 3*SLOT, 2, "R5");
        wait_to(p);
        rd(2'd2, 3, "R3", "frame left at load");
        check("R3", int'(frame_active), 1, "active after start");
        wait_to(p + SLOT - 1);
        rd(2'd2, 3, "R1", "frame left before first step");
        wait_to(p + SLOT);
        rd(2'd2, 2, "R4", "frame left after first step");
        wait_to(p + 3*SLOT - 1);
        rd(2'd2, 1, "R4", "frame left before expiry");
        wait_to(p + 3*SLOT + 1);
        rd(2'd2, 0, "R7", "frame left after expiry");
        check("R7", int'(frame_active), 0, "active after expiry");
        wait_to(p + 5*SLOT);
        rd(2'd2, 0, "R7", "frame left holds at zero");

        // gap countdown (R8 R9 R1)
        do_msg(k);
        expect_ev(k + 5*CPU, 4, "R8");
        wait_to(k);
        check("R8", int'(next_msg_ok), 0, "ok after load");
        wait_to(k + 2*CPU);
        rd(2'd3, 3, "R1", "gap left after two steps");
        wait_to(k + 5*CPU - 1);
        check("R8", int'(next_msg_ok), 0, "ok one cycle early");
        wait_to(k + 5*CPU + 20);
        rd(2'd3, 0, "R9", "gap left holds at zero");

        // retrigger mid-gap (R12)
        do_msg(k);
        wait_to(k + 5);
        do_msg(k2);
        expect_ev(k2 + 5*CPU, 4, "R12");
        wait_to(k + 5*CPU);
        check("R12", int'(next_msg_ok), 0, "ok at first gap end");
        wait_to(k2 + 5*CPU + 4);

        // auto-repeat then stop (R6 R10)
        wr(2'd0, 16'd2);
        auto_repeat = 1'b1;
        do_start(p);
        expect_ev(p, 1, "R6");
        expect_ev(p + 2*SLOT, 3, "R6");
        expect_ev(p + 4*SLOT, 3, "R6");
        wait_to(p + 2*SLOT + 1);
        rd(2'd2, 2, "R6", "frame left after reload");
        wait_to(p + 4*SLOT + 89);
        do_msg(k);
        wait_to(p + 4*SLOT + 99);
        do_stop(s);
        wait_to(s + 1);
        check("R10", int'(frame_active), 0, "active after stop");
        wait_to(s + 2*SLOT);
        rd(2'd2, 2, "R10", "frame left frozen");
        rd(2'd3, 1, "R10", "gap left frozen");
        check("R10", int'(next_msg_ok), 0, "ok frozen low");
        auto_repeat = 1'b0;

        // stop beats start (R10)
        start = 1'b1; stop = 1'b1;
        @(negedge clk);
        start = 1'b0; stop = 1'b0;
        check("R10", int'(frame_active), 0, "stop with start");
        rd(2'd2, 2, "R10", "frame left not reloaded");
        repeat (3*SLOT) @(negedge clk);

        n_chk++;
        if (exp_cyc.size() != 0) begin
            n_err++;
            $display("FAIL R5 missing events: actual=%0d expected=0", exp_cyc.size());
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule